// File: doc/BRIEF.md
# Dual-Channel DDR Sample Capture with Prefilled Clock-Crossing Buffer

This block receives two ADC channels that share one source-synchronous clock. Each channel delivers a 16-bit sample per clock cycle over an 8-bit bus that carries one half of the sample on each clock edge. The block assembles full samples in the ADC clock domain and places the channel A and channel B samples of one cycle together in a single 32-bit buffer entry. The entries cross into a free-running system clock domain through a 16-entry asynchronous FIFO. The two clocks have the same nominal rate but no phase relation.

The read side does not start emitting as soon as data arrives. It waits until at least four entries are stored, then emits one entry per system clock. This margin absorbs jitter and small rate differences between the domains. If the buffer runs dry while output is enabled, the block records an underflow, stops the output and waits for the four-entry margin again. A write that arrives while the buffer is full is dropped and recorded as an overflow. Each domain has its own synchronous reset.

Top module: `dual_adc_capture_buffer`

## Requirements
- R1: For each channel, bits [15:8] of a sample are the bus value at a rising ADC clock edge, and bits [7:0] are the value at the falling edge that follows it. Both channels use the one ADC clock.
- R2: Each buffer entry pairs the channel A and channel B samples of the same ADC cycle. Entries leave in the order they were captured, channel A on `out_a` and channel B on `out_b`.
- R3: A sample that arrives while the buffer holds 16 entries is discarded and sets `adc_overflow`. The flag stays set until `adc_rst`. Without such a write, the flag stays low.
- R4: After reset, `out_valid` stays low while fewer than 4 entries are stored.
- R5: Once output is enabled, `out_valid` is high on consecutive system clocks, one entry per cycle, for as long as the buffer is not empty.
- R6: If the buffer becomes empty while output is enabled, `sys_underflow` sets and stays set until `sys_rst`. `out_valid` drops, and output resumes only after 4 entries are stored again.
- R7: `sys_rst` clears `out_valid` and `sys_underflow`. `adc_rst` clears `adc_overflow`. The ADC clock edge on which `adc_rst` is first seen low writes no entry.
- R8: The read and write pointers cross domains in Gray code, changing at most one bit per clock of their own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| adc_clk | input | 1 | Source-synchronous ADC clock; data is valid at both edges |
| adc_rst | input | 1 | Synchronous active-high reset of the ADC-side logic |
| adc_a_ddr | input | 8 | Channel A bus: upper half at rising edge, lower half at falling edge |
| adc_b_ddr | input | 8 | Channel B bus: upper half at rising edge, lower half at falling edge |
| sys_clk | input | 1 | Free-running system clock |
| sys_rst | input | 1 | Synchronous active-high reset of the system-side logic |
| out_valid | output | 1 | High for each cycle that carries a sample pair |
| out_a | output | 16 | Channel A sample |
| out_b | output | 16 | Channel B sample |
| adc_overflow | output | 1 | Sticky flag for a dropped write (ADC domain) |
| sys_underflow | output | 1 | Sticky flag for the buffer running dry while enabled (system domain) |

## Verification
The assertions assume that the bus halves are stable around the ADC clock edge that samples them. They also assume that each reset is held for at least two clocks of its own domain before the other domain uses the buffer. The bench changes bus values only midway between ADC edges and holds both resets across several edges. The embedded checks also assume that the ADC clock may stop between samples. The bench uses exactly this, with random gaps and random edge spacing. It keeps the ADC rate at or below the system rate, except in one deliberate fast burst that forces an overflow.

// File: rtl/adc_cdc_pkg.sv
package adc_cdc_pkg;

    parameter int SAMPLE_W   = 16;
    parameter int HALF_W     = SAMPLE_W / 2;
    parameter int FIFO_DEPTH = 16;
    parameter int PREFILL    = 4;

    // One buffer entry: both channels of one ADC cycle
    typedef struct packed {
        logic [SAMPLE_W-1:0] ch_a;
        logic [SAMPLE_W-1:0] ch_b;
    } pair_t;

    typedef enum logic {
        RD_FILL = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/ddr_pair_capture.sv
module ddr_pair_capture
    import adc_cdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] din_a,
    input  logic [HALF_W-1:0] din_b,
    output pair_t             word,
    output logic              word_ok
);

    logic [HALF_W-1:0] rise_a, rise_b;
    logic [HALF_W-1:0] fall_a, fall_b;
    logic              primed;

    // Rising-edge half: upper byte of the sample
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_a <= '0;
            rise_b <= '0;
            primed <= 1'b0;
        end else begin
            rise_a <= din_a;
            rise_b <= din_b;
            primed <= 1'b1;
        end
    end

    // Falling-edge half: lower byte of the sample
    always_ff @(negedge clk) begin
        fall_a <= din_a;
        fall_b <= din_b;
    end

    // Both halves are registered; the pair is written at the next rising edge
    assign word.ch_a = {rise_a, fall_a};
    assign word.ch_b = {rise_b, fall_b};
    assign word_ok   = primed;

endmodule

// File: rtl/ptr_sync.sv
module ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
    import adc_cdc_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  pair_t         wr_data,
    input  logic [PW-1:0] rd_gray_sync,
    input  logic [AW-1:0] rd_addr,
    output logic [PW-1:0] wr_gray,
    output pair_t         rd_data,
    output logic          overflow
);

    pair_t         mem [DEPTH];
    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nx;
    logic          full;

    assign wbin_nx = wbin + 1'b1;
    // Full when the write pointer is one lap ahead of the synchronized read pointer
    assign full = (wr_gray == {~rd_gray_sync[PW-1:PW-2], rd_gray_sync[PW-3:0]});

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin     <= '0;
            wr_gray  <= '0;
            overflow <= 1'b0;
        end else if (wr_req) begin
            if (full) begin
                overflow <= 1'b1;
            end else begin
                wbin    <= wbin_nx;
                wr_gray <= wbin_nx ^ (wbin_nx >> 1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && wr_req && !full) begin
            mem[wbin[AW-1:0]] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // R3: a write into a full buffer raises the flag and leaves the pointer alone
    a_r3_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full) |=> (overflow && $stable(wr_gray)));
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    // R8: the crossing write pointer moves by one Gray step at most
    a_r8_wgray_step: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_gray ^ $past(wr_gray)));

endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
    import adc_cdc_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int FILL_MIN = PREFILL,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] wr_gray_sync,
    input  pair_t         rd_data,
    output logic [PW-1:0] rd_gray,
    output logic [AW-1:0] rd_addr,
    output logic          out_valid,
    output pair_t         out_pair,
    output logic          underflow
);

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    rd_state_e     state;
    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nx;
    logic [PW-1:0] wbin_seen;
    logic [PW-1:0] level;
    logic          empty;
    logic          rd_go;

    assign wbin_seen = gray_to_bin(wr_gray_sync);
    assign level     = wbin_seen - rbin;
    assign empty     = (rd_gray == wr_gray_sync);
    assign rd_go     = (state == RD_RUN) && !empty;
    assign rbin_nx   = rbin + 1'b1;
    assign rd_addr   = rbin[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RD_FILL;
            rbin      <= '0;
            rd_gray   <= '0;
            out_valid <= 1'b0;
            out_pair  <= '0;
            underflow <= 1'b0;
        end else begin
            out_valid <= rd_go;
            if (rd_go) begin
                out_pair <= rd_data;
                rbin     <= rbin_nx;
                rd_gray  <= rbin_nx ^ (rbin_nx >> 1);
            end
            case (state)
                RD_FILL: if (int'(level) >= FILL_MIN) state <= RD_RUN;
                RD_RUN: begin
                    if (empty) begin
                        state     <= RD_FILL;
                        underflow <= 1'b1;
                    end
                end
                default: state <= RD_FILL;
            endcase
        end
    end

    // R4: below the prefill margin the output stays quiet and waiting
    a_r4_hold_until_prefill: assert property (@(posedge clk) disable iff (rst)
        (state == RD_FILL && int'(level) < FILL_MIN) |=> (!out_valid && state == RD_FILL));
    // R6: running dry while enabled flags underflow and reopens the prefill wait
    a_r6_dry_returns_to_fill: assert property (@(posedge clk) disable iff (rst)
        (state == RD_RUN && empty) |=> (state == RD_FILL && underflow));
    a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);
    // R8: the crossing read pointer moves by one Gray step at most
    a_r8_rgray_step: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_gray ^ $past(rd_gray)));

endmodule

// File: rtl/dual_adc_capture_buffer.sv
module dual_adc_capture_buffer
    import adc_cdc_pkg::*;
(
    input  logic                adc_clk,
    input  logic                adc_rst,
    input  logic [HALF_W-1:0]   adc_a_ddr,
    input  logic [HALF_W-1:0]   adc_b_ddr,
    input  logic                sys_clk,
    input  logic                sys_rst,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_a,
    output logic [SAMPLE_W-1:0] out_b,
    output logic                adc_overflow,
    output logic                sys_underflow
);

    localparam int AW = $clog2(FIFO_DEPTH);
    localparam int PW = AW + 1;

    pair_t         cap_word;
    logic          cap_ok;
    pair_t         mem_rd;
    pair_t         out_pair;
    logic [PW-1:0] wgray, wgray_sys;
    logic [PW-1:0] rgray, rgray_adc;
    logic [AW-1:0] raddr;

    ddr_pair_capture u_capture (
        .clk     (adc_clk),
        .rst     (adc_rst),
        .din_a   (adc_a_ddr),
        .din_b   (adc_b_ddr),
        .word    (cap_word),
        .word_ok (cap_ok)
    );

    fifo_wr_ctrl #(.DEPTH(FIFO_DEPTH)) u_wr (
        .clk          (adc_clk),
        .rst          (adc_rst),
        .wr_req       (cap_ok),
        .wr_data      (cap_word),
        .rd_gray_sync (rgray_adc),
        .rd_addr      (raddr),
        .wr_gray      (wgray),
        .rd_data      (mem_rd),
        .overflow     (adc_overflow)
    );

    ptr_sync #(.W(PW)) u_sync_w2r (
        .clk (sys_clk),
        .rst (sys_rst),
        .d   (wgray),
        .q   (wgray_sys)
    );

    ptr_sync #(.W(PW)) u_sync_r2w (
        .clk (adc_clk),
        .rst (adc_rst),
        .d   (rgray),
        .q   (rgray_adc)
    );

    fifo_rd_ctrl #(.DEPTH(FIFO_DEPTH), .FILL_MIN(PREFILL)) u_rd (
        .clk          (sys_clk),
        .rst          (sys_rst),
        .wr_gray_sync (wgray_sys),
        .rd_data      (mem_rd),
        .rd_gray      (rgray),
        .rd_addr      (raddr),
        .out_valid    (out_valid),
        .out_pair     (out_pair),
        .underflow    (sys_underflow)
    );

    assign out_a = out_pair.ch_a;
    assign out_b = out_pair.ch_b;

endmodule

// File: tb/dual_adc_capture_buffer_tb.sv
`timescale 1ns/1ps
module dual_adc_capture_buffer_tb;

    logic        adc_clk = 1'b0;
    logic        adc_rst = 1'b1;
    logic [7:0]  adc_a_ddr = '0;
    logic [7:0]  adc_b_ddr = '0;
    logic        sys_clk = 1'b0;
    logic        sys_rst = 1'b1;
    logic        out_valid;
    logic [15:0] out_a, out_b;
    logic        adc_overflow, sys_underflow;

    int checks = 0;
    int fails  = 0;
    int vcount = 0;
    int run_len = 0;
    int max_run = 0;
    bit ignore_data = 1'b0;
    bit done = 1'b0;
    bit primed_m = 1'b0;
    logic [31:0] pend = '0;
    logic [31:0] exp_q[$];

    dual_adc_capture_buffer u_dut (
        .adc_clk       (adc_clk),
        .adc_rst       (adc_rst),
        .adc_a_ddr     (adc_a_ddr),
        .adc_b_ddr     (adc_b_ddr),
        .sys_clk       (sys_clk),
        .sys_rst       (sys_rst),
        .out_valid     (out_valid),
        .out_a         (out_a),
        .out_b         (out_b),
        .adc_overflow  (adc_overflow),
        .sys_underflow (sys_underflow)
    );

    // 125 MHz system clock
    always #4 sys_clk = ~sys_clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected pair word: channel A in [31:16], channel B in [15:0]
    function automatic logic [31:0] pair_word(input logic [15:0] a, input logic [15:0] b);
        return {a, b};
    endfunction

    // One ADC cycle: upper bytes at the rising edge, lower bytes at the falling edge (R1)
    task automatic adc_pulse(input logic [15:0] a, input logic [15:0] b, input int h);
        adc_a_ddr = a[15:8];
        adc_b_ddr = b[15:8];
        #(h);
        adc_clk = 1'b1;
        // model: this edge commits the previous sample if primed (R7)
        if (adc_rst) begin
            primed_m = 1'b0;
        end else begin
            if (primed_m) exp_q.push_back(pend);
            primed_m = 1'b1;
        end
        pend = pair_word(a, b);
        #(h);
        adc_a_ddr = a[7:0];
        adc_b_ddr = b[7:0];
        #(h);
        adc_clk = 1'b0;
        #(h);
    endtask

    task automatic sys_wait(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic reset_both();
        adc_rst = 1'b1;
        @(negedge sys_clk);
        sys_rst = 1'b1;
        adc_pulse(16'h0000, 16'h0000, 2);
        adc_pulse(16'h0000, 16'h0000, 2);
        sys_wait(3);
        adc_rst = 1'b0;
        sys_rst = 1'b0;
        exp_q.delete();
        vcount = 0;
        max_run = 0;
    endtask

    // Output monitor: data order and per-cycle streaming (R1, R2, R5)
    always @(negedge sys_clk) begin
        if (!sys_rst && out_valid) begin
            vcount++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
            if (!ignore_data) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected output word", {out_a, out_b}, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check({out_a, out_b} == e, "R1/R2", "sample pair", {out_a, out_b}, e);
                end
            end
        end else begin
            run_len = 0;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            check(1'b0, "R5", "watchdog expired", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C0A));
        reset_both();
        sys_wait(1);
        check(out_valid == 1'b0, "R7", "out_valid after reset", 32'(out_valid), 32'h0);
        check(sys_underflow == 1'b0, "R7", "underflow after reset", 32'(sys_underflow), 32'h0);
        check(adc_overflow == 1'b0, "R7", "overflow after reset", 32'(adc_overflow), 32'h0);

        // R4: three committed entries keep the output off
        adc_pulse(16'hA55A, 16'h3CC3, 2);
        adc_pulse(16'h0102, 16'hFEFD, 2);
        adc_pulse(16'hFF00, 16'h00FF, 2);
        adc_pulse(16'h8001, 16'h7FFE, 2);
        sys_wait(12);
        check(vcount == 0, "R4", "no output with 3 stored", 32'(vcount), 32'h0);
        check(exp_q.size() == 3, "R7", "first edge after reset writes nothing", 32'(exp_q.size()), 32'd3);

        // fourth entry enables the output: 4 words on consecutive cycles
        adc_pulse(16'h1234, 16'h5678, 2);
        max_run = 0;
        sys_wait(15);
        check(vcount == 4, "R4", "words after prefill", 32'(vcount), 32'd4);
        check(max_run == 4, "R5", "consecutive output run", 32'(max_run), 32'd4);
        check(sys_underflow == 1'b1, "R6", "underflow after draining", 32'(sys_underflow), 32'h1);
        check(out_valid == 1'b0, "R6", "output stopped after draining", 32'(out_valid), 32'h0);

        // R6: prefill wait repeats after underflow
        vcount = 0;
        adc_pulse(16'h1111, 16'h2222, 3);
        adc_pulse(16'h3333, 16'h4444, 3);
        adc_pulse(16'h5555, 16'h6666, 3);
        sys_wait(12);
        check(vcount == 0, "R6", "prefill wait repeats", 32'(vcount), 32'h0);
        check(sys_underflow == 1'b1, "R6", "underflow stays set", 32'(sys_underflow), 32'h1);
        adc_pulse(16'h7777, 16'h8888, 3);
        sys_wait(15);
        check(vcount == 4, "R6", "output resumes at prefill", 32'(vcount), 32'd4);

        // random samples, random ADC edge spacing and gaps, ADC rate never above system rate
        for (int i = 0; i < 300; i++) begin
            int h;
            h = 2 + int'($urandom_range(1, 0));
            adc_pulse(16'($urandom), 16'($urandom), h);
            #($urandom_range(20, 0));
        end
        sys_wait(20);
        check(adc_overflow == 1'b0, "R3", "no overflow at sustainable rate", 32'(adc_overflow), 32'h0);
        check(exp_q.size() < 4, "R4", "left below prefill only", 32'(exp_q.size()), 32'd3);

        // R3: fast burst overruns the buffer
        ignore_data = 1'b1;
        for (int i = 0; i < 50; i++) begin
            adc_pulse(16'(i), 16'(~i), 1);
        end
        check(adc_overflow == 1'b1, "R3", "overflow after burst", 32'(adc_overflow), 32'h1);
        sys_wait(40);
        for (int i = 0; i < 3; i++) begin
            adc_pulse(16'h0F0F, 16'hF0F0, 3);
        end
        check(adc_overflow == 1'b1, "R3", "overflow stays set", 32'(adc_overflow), 32'h1);

        // R7: resets clear both flags and the output
        reset_both();
        ignore_data = 1'b0;
        sys_wait(1);
        check(adc_overflow == 1'b0, "R7", "overflow cleared", 32'(adc_overflow), 32'h0);
        check(sys_underflow == 1'b0, "R7", "underflow cleared", 32'(sys_underflow), 32'h0);
        check(out_valid == 1'b0, "R7", "out_valid cleared", 32'(out_valid), 32'h0);

        // normal capture again after reset
        for (int i = 0; i < 5; i++) begin
            adc_pulse(16'hC000 + 16'(i), 16'h0C00 + 16'(i), 2);
        end
        sys_wait(15);
        check(vcount == 4, "R2", "capture after reset", 32'(vcount), 32'd4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule